// File: doc/BRIEF.md
# Multi-Function 40-bit Barrel Shifter

This unit takes one operand of 16, 32 or 40 bits and turns it into a result in a single clock cycle. It can shift arithmetically or logically, rotate, test or set one bit, join two half-words into a word, extract a half-word with sign extension, and count redundant sign bits to prepare a normalising shift. An operation code selects the function. A two-bit selector fixes the working width. A 7-bit two's-complement amount serves both as the shift count and as the bit index.

Each operation reads only the low W bits of operand A, where W is the selected width. The result lies in the low W bits of the output and every bit above W is zero. Packing is the one exception: it always produces a 32-bit word. Every cycle the unit registers the result and the bit-test flag, so a new operation can start each clock. It has no handshake.

Top module: `bshift40_unit`

## Requirements
- R1: While `rst` is high at a rising edge, `res_o` and `flag_o` become zero at that edge.
- R2: The inputs present at a rising edge determine `res_o` and `flag_o` just after that edge, and the outputs do not change between edges.
- R3: `wsel_i` = 0 selects W = 16, 1 selects W = 32, and 2 or 3 selects W = 40. Only bits W-1..0 of `opa_i` take part. For every operation except pack, result bits 39..W are zero.
- R4: Arithmetic shift (`op_i` = 0): a positive `amt_i` shifts left and fills with zeros. A negative `amt_i` shifts right by its magnitude and fills with bit W-1 of the operand. A right shift of W or more gives all copies of the sign bit, and a left shift of W or more gives zero.
- R5: Logical shift (`op_i` = 1) follows the same direction rule but fills with zeros in both directions. A magnitude of W or more gives zero, and an amount of zero returns the operand unchanged.
- R6: Rotate (`op_i` = 2) moves bits circularly within the W-bit field: left for a positive amount and right for a negative one. The rotate distance is the magnitude modulo W.
- R7: Bit test (`op_i` = 3): `amt_i` is read as an unsigned index 0..127. `flag_o` is the operand bit at that index, or 0 when the index is W or more. `res_o` is the operand.
- R8: Bit set (`op_i` = 4): `res_o` is the operand with the bit at the unsigned index `amt_i` forced to 1. An index of W or more leaves the operand unchanged.
- R9: Pack (`op_i` = 5) ignores `wsel_i`. It gives `opa_i[15:0]` in result bits 31:16, `opb_i` in bits 15:0, and zero in bits 39:32.
- R10: Unpack (`op_i` = 6): `amt_i[0]` = 0 selects `opa_i[15:0]` and 1 selects `opa_i[31:16]`. The chosen half-word is sign-extended to W bits.
- R11: Exponent (`op_i` = 7) returns the number of consecutive bits directly below bit W-1 that equal bit W-1. This equals the left shift that normalises the operand. An all-zero or all-one operand returns W-1.
- R12: `flag_o` is 0 after every operation other than bit test.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 3 | Operation code (0..7, see requirements) |
| wsel_i | input | 2 | Working width selector |
| opa_i | input | 40 | Main operand |
| opb_i | input | 16 | Low half-word source for pack |
| amt_i | input | 7 | Signed shift amount, or unsigned bit index / half select |
| res_o | output | 40 | Registered result |
| flag_o | output | 1 | Registered bit-test flag |

## Verification
The datapath is combinational and feeds a single register, so any wrong internal value reaches `res_o` or `flag_o` on the edge after the faulty inputs and never persists beyond that edge. A broken width mask shows up as stray high bits or as lost top bits, depending on the width selected. A wrong sign choice shows only on negative operands shifted right. A bad modulo step shows only on rotates of at least W, and a wrong index range check shows only for indices at or above W. For these reasons the bench mixes random operands with directed vectors placed at those boundaries. It also checks that the outputs hold steady between edges.

// File: rtl/bshift_pkg.sv
package bshift_pkg;
  typedef enum logic [2:0] {
    OP_ASH  = 3'd0,
    OP_LSH  = 3'd1,
    OP_ROT  = 3'd2,
    OP_BTST = 3'd3,
    OP_BSET = 3'd4,
    OP_PACK = 3'd5,
    OP_UNPK = 3'd6,
    OP_EXP  = 3'd7
  } bs_op_e;

  typedef enum logic [1:0] {
    SK_ASH = 2'd0,
    SK_LSH = 2'd1,
    SK_ROT = 2'd2
  } bs_shift_kind_e;
endpackage

// File: rtl/bshift_shifter.sv
module bshift_shifter
  import bshift_pkg::*;
#(
  parameter int ACC_W = 40,
  parameter int AMT_W = 7
) (
  input  bs_shift_kind_e   kind_i,
  input  logic [AMT_W-1:0] wval_i,
  input  logic [ACC_W-1:0] mask_i,
  input  logic [ACC_W-1:0] opnd_i,
  input  logic [AMT_W-1:0] amt_i,
  output logic [ACC_W-1:0] res_o
);
  logic             neg;
  logic [AMT_W-1:0] mag;
  logic [AMT_W-1:0] rmod;
  logic [AMT_W-1:0] rk;
  logic             sgn;
  logic             beyond;
  logic [ACC_W-1:0] lft;
  logic [ACC_W-1:0] rgt;
  logic [ACC_W-1:0] fill;
  logic [ACC_W-1:0] rot;

  always_comb begin
    neg    = amt_i[AMT_W-1];
    mag    = neg ? (~amt_i + 1'b1) : amt_i;
    // top bit of the working field, found via the mask edge
    sgn    = |(opnd_i & mask_i & ~(mask_i >> 1));
    beyond = (mag >= wval_i);
    lft    = beyond ? '0 : ((opnd_i << mag) & mask_i);
    rgt    = opnd_i >> mag;
    fill   = (kind_i == SK_ASH && sgn) ? (mask_i & ~(mask_i >> mag)) : '0;
    rmod   = mag % wval_i;
    rk     = (neg && rmod != '0) ? (wval_i - rmod) : rmod;
    rot    = ((opnd_i << rk) | (opnd_i >> (wval_i - rk))) & mask_i;
    unique case (kind_i)
      SK_ROT:  res_o = rot;
      default: res_o = neg ? (rgt | fill) : lft;
    endcase
    // R6
    if (kind_i == SK_ROT) begin
      rot_popcount_chk: assert ($countones(res_o) == $countones(opnd_i));
    end
  end
endmodule

// File: rtl/bshift_bitops.sv
module bshift_bitops
  import bshift_pkg::*;
#(
  parameter int ACC_W  = 40,
  parameter int HALF_W = 16,
  parameter int AMT_W  = 7
) (
  input  bs_op_e            op_i,
  input  logic [AMT_W-1:0]  wval_i,
  input  logic [ACC_W-1:0]  mask_i,
  input  logic [ACC_W-1:0]  raw_a_i,
  input  logic [HALF_W-1:0] opb_i,
  input  logic [AMT_W-1:0]  amt_i,
  output logic [ACC_W-1:0]  res_o,
  output logic              flag_o
);
  localparam int WORD_W = 2 * HALF_W;

  logic [ACC_W-1:0]  opm;
  logic [ACC_W-1:0]  hit;
  logic [HALF_W-1:0] half;
  logic [ACC_W-1:0]  unp;
  logic [ACC_W-1:0]  pck;

  always_comb begin
    opm  = raw_a_i & mask_i;
    hit  = (amt_i < wval_i) ? ({{(ACC_W-1){1'b0}}, 1'b1} << amt_i) : '0;
    half = amt_i[0] ? raw_a_i[WORD_W-1:HALF_W] : raw_a_i[HALF_W-1:0];
    unp  = {{(ACC_W-HALF_W){half[HALF_W-1]}}, half} & mask_i;
    pck  = {{(ACC_W-WORD_W){1'b0}}, raw_a_i[HALF_W-1:0], opb_i};
    flag_o = 1'b0;
    unique case (op_i)
      OP_BTST: begin
        res_o  = opm;
        flag_o = |(opm & hit);
      end
      OP_BSET: res_o = opm | hit;
      OP_PACK: res_o = pck;
      OP_UNPK: res_o = unp;
      default: res_o = opm;
    endcase
    // R8
    bit_onehot_chk: assert ($onehot0(hit));
  end
endmodule

// File: rtl/bshift_expdet.sv
module bshift_expdet #(
  parameter int ACC_W = 40,
  parameter int AMT_W = 7
) (
  input  logic [AMT_W-1:0] wval_i,
  input  logic [ACC_W-1:0] mask_i,
  input  logic [ACC_W-1:0] opnd_i,
  output logic [AMT_W-1:0] cnt_o
);
  logic sgn;
  logic run;

  always_comb begin
    sgn   = |(opnd_i & mask_i & ~(mask_i >> 1));
    run   = 1'b1;
    cnt_o = '0;
    for (int i = ACC_W - 2; i >= 0; i--) begin
      if (mask_i[i+1] && run) begin
        if (opnd_i[i] == sgn) cnt_o = cnt_o + 1'b1;
        else                  run   = 1'b0;
      end
    end
    // R11
    exp_range_chk: assert (cnt_o < wval_i);
  end
endmodule

// File: rtl/bshift40_unit.sv
module bshift40_unit
  import bshift_pkg::*;
#(
  parameter int ACC_W  = 40,
  parameter int HALF_W = 16,
  parameter int AMT_W  = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        op_i,
  input  logic [1:0]        wsel_i,
  input  logic [ACC_W-1:0]  opa_i,
  input  logic [HALF_W-1:0] opb_i,
  input  logic [AMT_W-1:0]  amt_i,
  output logic [ACC_W-1:0]  res_o,
  output logic              flag_o
);
  localparam int WORD_W = 2 * HALF_W;

  bs_op_e           op;
  bs_shift_kind_e   kind;
  logic [AMT_W-1:0] wval;
  logic [ACC_W-1:0] mask;
  logic [ACC_W-1:0] opm;
  logic [ACC_W-1:0] sh_res;
  logic [ACC_W-1:0] bit_res;
  logic             bit_flag;
  logic [AMT_W-1:0] exp_cnt;
  logic [ACC_W-1:0] nxt;
  logic [ACC_W-1:0] res_q;
  logic             flag_q;

  assign op = bs_op_e'(op_i);

  always_comb begin
    unique case (wsel_i)
      2'd0:    wval = AMT_W'(HALF_W);
      2'd1:    wval = AMT_W'(WORD_W);
      default: wval = AMT_W'(ACC_W);
    endcase
    mask = {ACC_W{1'b1}} >> (AMT_W'(ACC_W) - wval);
    opm  = opa_i & mask;
    unique case (op)
      OP_ASH:  kind = SK_ASH;
      OP_LSH:  kind = SK_LSH;
      default: kind = SK_ROT;
    endcase
  end

  bshift_shifter #(.ACC_W(ACC_W), .AMT_W(AMT_W)) u_shift (
    .kind_i (kind),
    .wval_i (wval),
    .mask_i (mask),
    .opnd_i (opm),
    .amt_i  (amt_i),
    .res_o  (sh_res)
  );

  bshift_bitops #(.ACC_W(ACC_W), .HALF_W(HALF_W), .AMT_W(AMT_W)) u_bits (
    .op_i    (op),
    .wval_i  (wval),
    .mask_i  (mask),
    .raw_a_i (opa_i),
    .opb_i   (opb_i),
    .amt_i   (amt_i),
    .res_o   (bit_res),
    .flag_o  (bit_flag)
  );

  bshift_expdet #(.ACC_W(ACC_W), .AMT_W(AMT_W)) u_exp (
    .wval_i (wval),
    .mask_i (mask),
    .opnd_i (opm),
    .cnt_o  (exp_cnt)
  );

  always_comb begin
    unique case (op)
      OP_ASH, OP_LSH, OP_ROT: nxt = sh_res;
      OP_EXP:                 nxt = ACC_W'(exp_cnt);
      default:                nxt = bit_res;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      res_q  <= nxt;
      flag_q <= bit_flag;
    end
  end

  assign res_o  = res_q;
  assign flag_o = flag_q;

  // R12
  flag_btst_only_chk: assert property (@(posedge clk) disable iff (rst)
    (op != OP_BTST) |=> !flag_o);

  // R3
  upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (op != OP_PACK) |=> ((res_o & ~$past(mask)) == '0));

  // R9
  pack_place_chk: assert property (@(posedge clk) disable iff (rst)
    (op == OP_PACK) |=> (res_o[WORD_W-1:HALF_W] == $past(opa_i[HALF_W-1:0])
                         && res_o[HALF_W-1:0] == $past(opb_i)
                         && res_o[ACC_W-1:WORD_W] == '0));

  // R5
  lsh_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (op == OP_LSH && amt_i == '0) |=> (res_o == $past(opa_i & mask)));
endmodule

// File: tb/sim_bshift40_unit.sv
`timescale 1ns/1ps
module sim_bshift40_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  op_i = '0;
  logic [1:0]  wsel_i = '0;
  logic [39:0] opa_i = '0;
  logic [15:0] opb_i = '0;
  logic [6:0]  amt_i = '0;
  logic [39:0] res_o;
  logic        flag_o;

  int checks = 0;
  int fails  = 0;
  logic [39:0] prev_res = '0;
  logic        prev_flag = 1'b0;
  bit          done = 0;

  always #4 clk = ~clk;

  bshift40_unit u0 (
    .clk(clk), .rst(rst), .op_i(op_i), .wsel_i(wsel_i),
    .opa_i(opa_i), .opb_i(opb_i), .amt_i(amt_i),
    .res_o(res_o), .flag_o(flag_o)
  );

  function automatic logic [40:0] model(input logic [2:0] op, input logic [1:0] ws,
                                        input logic [39:0] a, input logic [15:0] b,
                                        input logic [6:0] amt);
    int w, s, idx, j, cnt;
    logic [39:0] r;
    logic f, stop;
    logic [15:0] h;
    w = (ws == 2'd0) ? 16 : (ws == 2'd1) ? 32 : 40;
    s = int'($signed(amt));
    idx = int'(amt);
    r = '0; f = 1'b0;
    case (op)
      3'd0, 3'd1: for (int i = 0; i < w; i++) begin
        j = i - s;
        if (j < 0) r[i] = 1'b0;
        else if (j >= w) r[i] = (op == 3'd0) ? a[w-1] : 1'b0;
        else r[i] = a[j];
      end
      3'd2: for (int i = 0; i < w; i++) begin
        j = (((i - s) % w) + w) % w;
        r[i] = a[j];
      end
      3'd3, 3'd4: begin
        for (int i = 0; i < w; i++) r[i] = a[i];
        if (idx < w) begin
          if (op == 3'd3) f = a[idx];
          else r[idx] = 1'b1;
        end
      end
      3'd5: r = {8'h00, a[15:0], b};
      3'd6: begin
        h = amt[0] ? a[31:16] : a[15:0];
        for (int i = 0; i < w; i++) r[i] = (i < 16) ? h[i] : h[15];
      end
      default: begin
        cnt = 0; stop = 1'b0;
        for (int i = w - 2; i >= 0; i--) begin
          if (!stop && a[i] == a[w-1]) cnt++;
          else stop = 1'b1;
        end
        r = 40'(cnt);
      end
    endcase
    return {f, r};
  endfunction

  function automatic string tag_of(input logic [2:0] op);
    case (op)
      3'd0: return "R4 (R3 R12)";
      3'd1: return "R5 (R3 R12)";
      3'd2: return "R6 (R3 R12)";
      3'd3: return "R7 (R3)";
      3'd4: return "R8 (R3 R12)";
      3'd5: return "R9 (R12)";
      3'd6: return "R10 (R3 R12)";
      default: return "R11 (R3 R12)";
    endcase
  endfunction

  task automatic check(input string tag, input logic [39:0] r, input logic fl,
                       input logic [39:0] er, input logic ef);
    checks++;
    if (r !== er || fl !== ef) begin
      fails++;
      $display("FAIL %s res=%h exp=%h flag=%b exp=%b", tag, r, er, fl, ef);
    end
  endtask

  task automatic run(input logic [2:0] op, input logic [1:0] ws, input logic [39:0] a,
                     input logic [15:0] b, input logic [6:0] amt);
    logic [40:0] e;
    @(negedge clk);
    op_i = op; wsel_i = ws; opa_i = a; opb_i = b; amt_i = amt;
    e = model(op, ws, a, b, amt);
    #1;
    check("R2 hold", res_o, flag_o, prev_res, prev_flag);
    @(negedge clk);
    check(tag_of(op), res_o, flag_o, e[39:0], e[40]);
    prev_res = e[39:0]; prev_flag = e[40];
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state, still holding with inputs idle after release
    check("R1 reset", res_o, flag_o, 40'h0, 1'b0);

    // R4 arithmetic shifts
    run(3'd0, 2'd2, 40'h80_0000_0000, 16'h0, -7'sd5);
    run(3'd0, 2'd0, 40'h0000_8001, 16'h0, -7'sd40);
    run(3'd0, 2'd1, 40'h1234_5678, 16'h0, 7'sd3);
    run(3'd0, 2'd2, 40'hF0_0000_0001, 16'h0, -7'sd64);
    run(3'd0, 2'd0, 40'h0000_0001, 16'h0, 7'sd16);
    // R5 logical shifts
    run(3'd1, 2'd0, 40'hAB_CDEF_FFFF, 16'h0, -7'sd1);
    run(3'd1, 2'd0, 40'h0000_FFFF, 16'h0, 7'sd16);
    run(3'd1, 2'd1, 40'hFF_8765_4321, 16'h0, 7'sd0);
    // R6 rotate
    run(3'd2, 2'd0, 40'h0000_8001, 16'h0, 7'sd1);
    run(3'd2, 2'd2, 40'h00_0000_0001, 16'h0, -7'sd1);
    run(3'd2, 2'd2, 40'h12_3456_789A, 16'h0, 7'sd45);
    run(3'd2, 2'd1, 40'h8000_0003, 16'h0, -7'sd33);
    // R7 bit test
    run(3'd3, 2'd2, 40'h80_0000_0000, 16'h0, 7'd39);
    run(3'd3, 2'd1, 40'h80_FFFF_FFFF, 16'h0, 7'd39);
    run(3'd3, 2'd2, 40'hFF_FFFF_FFFF, 16'h0, 7'h7F);
    // R8 bit set
    run(3'd4, 2'd0, 40'h0000_0000, 16'h0, 7'd20);
    run(3'd4, 2'd2, 40'h00_0000_0000, 16'h0, 7'd39);
    // R9 pack
    run(3'd5, 2'd0, 40'hEE_1111_BEEF, 16'hCAFE, 7'd0);
    // R10 unpack
    run(3'd6, 2'd2, 40'h00_9000_1234, 16'h0, 7'd1);
    run(3'd6, 2'd0, 40'h00_9000_F234, 16'h0, 7'd0);
    // R11 exponent
    run(3'd7, 2'd1, 40'h0, 16'h0, 7'd0);
    run(3'd7, 2'd1, 40'hFFFF_FFFF, 16'h0, 7'd0);
    run(3'd7, 2'd0, 40'h0000_4000, 16'h0, 7'd0);
    run(3'd7, 2'd2, 40'hFF_FFFF_F800, 16'h0, 7'd0);

    for (int n = 0; n < 600; n++) begin
      run(3'($urandom_range(0, 7)), 2'($urandom_range(0, 3)),
          {8'($urandom), 32'($urandom)}, 16'($urandom), 7'($urandom));
    end

    // R1: mid-run reset clears outputs
    @(negedge clk);
    op_i = 3'd4; wsel_i = 2'd2; opa_i = '1; amt_i = 7'd0; rst = 1'b1;
    @(negedge clk);
    check("R1 mid reset", res_o, flag_o, 40'h0, 1'b0);
    rst = 1'b0;

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule